// File: doc/BRIEF.md
# Parallel Two-Tone Phase Lanes

This block supplies phase values to a synthesizer that must emit sixteen output samples on every fabric clock. Two tones are handled independently. Each tone keeps one phase register per sample slot of the clock, so lane k holds the phase of sample k within the current group. Once the lanes are set up, every lane advances by sixteen frequency steps per clock. The group of sixteen phases therefore continues the same waveform that one register stepping sixteen times faster would give.

A synchronous sync input restarts the tones. While sync is high, lane 0 takes the tone's start phase and each later lane takes its lower neighbour's previous value plus one frequency word. Holding sync for sixteen or more clocks leaves the lanes evenly staggered. The per-clock step of each tone is captured only while sync is high. A placeholder phase-to-sample stage adds the two tones' lane-k phases into sample k and registers the result. The sixteen samples are packed into one wide bus. A parameter can tie that bus to zero.

Top module: `twotone_phase_lanes`

## Requirements
- R1: A synchronous active-high reset clears every phase lane, both step registers and every sample to zero.
- R2: On a clock with sync high, lane 0 of each tone loads that tone's start phase.
- R3: On a clock with sync high, lane k (1 to 15) of each tone loads the previous value of lane k-1 plus that tone's frequency word, modulo 2^16. After at least 16 sync clocks, lane k holds start + k*word.
- R4: On a clock with sync high, each tone's step register loads the frequency word times 16, modulo 2^16 (the top four bits are dropped). While sync is low, the step holds, and changes on the word or start inputs have no effect on the lanes.
- R5: On a clock with sync low, every lane adds its tone's stored step, modulo 2^16. At clock n after a sync of 16 or more cycles, lane k equals start + k*word + 16*n*word, modulo 2^16.
- R6: The sample registers load zero on every clock with sync high.
- R7: On a clock with sync low, sample k loads (tone A lane k + tone B lane k) modulo 2^16, using the lane values from before that clock edge.
- R8: Lane and sample k occupy bits 16k+15 down to 16k of their packed buses: lane 0 is in bits 15:0 and lane 15 is in bits 255:240.
- R9: With DATAPATH_OFF set, the sample bus is zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | Restart and stagger the lanes |
| word_a | input | 16 | Tone A frequency word |
| word_b | input | 16 | Tone B frequency word |
| start_a | input | 16 | Tone A start phase |
| start_b | input | 16 | Tone B start phase |
| phase_a | output | 256 | Tone A lanes, lane k in bits 16k+15:16k |
| phase_b | output | 256 | Tone B lanes, lane k in bits 16k+15:16k |
| samples | output | 256 | Placeholder samples, sample k in bits 16k+15:16k |

## Verification
The bench uses a tone B word above 0x0FFF, so its step shows the dropped top bits. A design that kept 20 bits or shifted the wrong way would drift from the model after the first clock. A short sync of five cycles leaves the upper lanes half ramped. A design that loaded every lane straight from the start phase, or that captured lanes from the same cycle's neighbour, would disagree lane by lane. The bench changes the frequency word and start phase while sync is low to expose a step that follows the live input. The bench also checks the sample bus on the first clock after sync falls, to catch a sample path with the wrong lane order or the wrong latency. A second instance built with the datapath off must show zero samples throughout.

// File: rtl/twotone_phase_lanes.sv
module twotone_phase_lanes #(
  parameter int LANES        = 16,
  parameter int PW           = 16,
  parameter bit DATAPATH_OFF = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync,
  input  logic [PW-1:0]       word_a,
  input  logic [PW-1:0]       word_b,
  input  logic [PW-1:0]       start_a,
  input  logic [PW-1:0]       start_b,
  output logic [LANES*PW-1:0] phase_a,
  output logic [LANES*PW-1:0] phase_b,
  output logic [LANES*PW-1:0] samples
);
  localparam int SH = $clog2(LANES);

  logic [PW-1:0] lane_a [LANES];
  logic [PW-1:0] lane_b [LANES];
  logic [PW-1:0] step_a, step_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_a <= '0;
      step_b <= '0;
      for (int k = 0; k < LANES; k++) begin
        lane_a[k] <= '0;
        lane_b[k] <= '0;
      end
    end else if (sync) begin
      step_a    <= word_a << SH;
      step_b    <= word_b << SH;
      lane_a[0] <= start_a;
      lane_b[0] <= start_b;
      for (int k = 1; k < LANES; k++) begin
        lane_a[k] <= lane_a[k-1] + word_a;
        lane_b[k] <= lane_b[k-1] + word_b;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        lane_a[k] <= lane_a[k] + step_a;
        lane_b[k] <= lane_b[k] + step_b;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign phase_a[g*PW +: PW] = lane_a[g];
    assign phase_b[g*PW +: PW] = lane_b[g];
  end

  if (DATAPATH_OFF) begin : g_off
    assign samples = '0;
  end else begin : g_on
    logic [PW-1:0] smp [LANES];
    always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++)
        if (rst || sync) smp[k] <= '0;
        else             smp[k] <= lane_a[k] + lane_b[k];
    end
    for (genvar g = 0; g < LANES; g++) begin : g_out
      assign samples[g*PW +: PW] = smp[g];
    end
  end
endmodule

module twotone_phase_lanes_chk #(
  parameter int LANES        = 16,
  parameter int PW           = 16,
  parameter bit DATAPATH_OFF = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                sync,
  input logic [PW-1:0]       word_a,
  input logic [PW-1:0]       start_a,
  input logic [PW-1:0]       step_a,
  input logic [PW-1:0]       step_b,
  input logic [LANES*PW-1:0] phase_a,
  input logic [LANES*PW-1:0] phase_b,
  input logic [LANES*PW-1:0] samples
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (phase_a == '0 && phase_b == '0 && samples == '0));

  a_r2_lane0_start: assert property (@(posedge clk) disable iff (rst)
    sync |=> phase_a[PW-1:0] == $past(start_a));

  a_r3_lane_chain: assert property (@(posedge clk) disable iff (rst)
    sync |=> phase_a[2*PW-1:PW] == PW'($past(phase_a[PW-1:0]) + $past(word_a)));

  a_r4_step_holds: assert property (@(posedge clk) disable iff (rst)
    !sync |=> ($stable(step_a) && $stable(step_b)));

  a_r5_lane_advance: assert property (@(posedge clk) disable iff (rst)
    !sync |=> phase_a[LANES*PW-1 -: PW] ==
              PW'($past(phase_a[LANES*PW-1 -: PW]) + $past(step_a)));

  a_r6_zero_on_sync: assert property (@(posedge clk) disable iff (rst)
    sync |=> samples == '0);

  a_r7_sample_sum: assert property (@(posedge clk) disable iff (rst)
    !sync |=> (DATAPATH_OFF ||
               samples[PW-1:0] == PW'($past(phase_a[PW-1:0]) + $past(phase_b[PW-1:0]))));

  a_r9_off_zero: assert property (@(posedge clk) disable iff (rst)
    DATAPATH_OFF |-> samples == '0);
endmodule

bind twotone_phase_lanes twotone_phase_lanes_chk #(
  .LANES(LANES), .PW(PW), .DATAPATH_OFF(DATAPATH_OFF)
) u_chk (
  .clk(clk), .rst(rst), .sync(sync), .word_a(word_a), .start_a(start_a),
  .step_a(step_a), .step_b(step_b), .phase_a(phase_a), .phase_b(phase_b),
  .samples(samples)
);

// File: tb/tb_twotone_phase_lanes.sv
module tb_twotone_phase_lanes;
  logic clk = 0;
  logic rst = 1, sync = 0;
  logic [15:0] word_a = 0, word_b = 0, start_a = 0, start_b = 0;
  logic [255:0] phase_a, phase_b, samples, phase_a2, phase_b2, samples2;
  int checks = 0, fails = 0;
  bit closed_on = 0;
  int n_after = 0;
  logic [15:0] ca_word, ca_start, cb_word, cb_start;

  always #4 clk = ~clk;

  twotone_phase_lanes dut (.clk(clk), .rst(rst), .sync(sync), .word_a(word_a),
    .word_b(word_b), .start_a(start_a), .start_b(start_b),
    .phase_a(phase_a), .phase_b(phase_b), .samples(samples));

  twotone_phase_lanes #(.DATAPATH_OFF(1)) dut_off (.clk(clk), .rst(rst), .sync(sync),
    .word_a(word_a), .word_b(word_b), .start_a(start_a), .start_b(start_b),
    .phase_a(phase_a2), .phase_b(phase_b2), .samples(samples2));

  int ma[16], mb[16], ms[16];
  int sa = 0, sb = 0;

  always @(posedge clk) begin
    int na[16], nb[16];
    if (rst) begin
      foreach (ma[k]) begin ma[k] = 0; mb[k] = 0; ms[k] = 0; end
      sa = 0; sb = 0;
    end else if (sync) begin
      na[0] = start_a; nb[0] = start_b;
      for (int k = 1; k < 16; k++) begin
        na[k] = (ma[k-1] + word_a) % 65536;
        nb[k] = (mb[k-1] + word_b) % 65536;
      end
      sa = (word_a * 16) % 65536; sb = (word_b * 16) % 65536;
      foreach (ma[k]) begin ma[k] = na[k]; mb[k] = nb[k]; ms[k] = 0; end
    end else begin
      foreach (ma[k]) begin
        ms[k] = (ma[k] + mb[k]) % 65536;
        ma[k] = (ma[k] + sa) % 65536;
        mb[k] = (mb[k] + sb) % 65536;
      end
    end
  end

  task automatic chk(input logic [15:0] act, input int exp, input string tag);
    checks++;
    if (act !== 16'(exp)) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, 16'(exp));
    end
  endtask

  // R8 packing: lane k read from bits 16k+15:16k
  always @(negedge clk) if (!rst) begin
    for (int k = 0; k < 16; k++) begin
      chk(phase_a[k*16 +: 16], ma[k], "R3/R5/R8 tone A lane");
      chk(phase_b[k*16 +: 16], mb[k], "R3/R5/R8 tone B lane");
      chk(samples[k*16 +: 16], ms[k], "R6/R7/R8 sample");
      chk(samples2[k*16 +: 16], 0, "R9 disabled samples");
    end
    if (closed_on) begin
      for (int k = 0; k < 16; k++) begin
        chk(phase_a[k*16 +: 16], ca_start + k*ca_word + 16*n_after*ca_word, "R5 closed form A");
        chk(phase_b[k*16 +: 16], cb_start + k*cb_word + 16*n_after*cb_word, "R5 closed form B");
      end
      n_after++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk(phase_a[15:0], 0, "R1 reset lane A0"); chk(phase_b[255:240], 0, "R1 reset lane B15");
    chk(samples[15:0], 0, "R1 reset sample0");
    rst = 0;
    cyc(2);
    // R2 R3 R4: long sync, tone B word with top bits set
    word_a = 16'h0123; start_a = 16'h1000; word_b = 16'hF00D; start_b = 16'hFFF0;
    sync = 1; cyc(20);
    sync = 0;
    ca_word = word_a; ca_start = start_a; cb_word = word_b; cb_start = start_b;
    n_after = 0; closed_on = 1;
    cyc(3);
    // R4: inputs changed while sync low must not matter
    word_a = 16'h7777; start_a = 16'h5555; word_b = 16'h0001; start_b = 16'h0002;
    cyc(30);
    closed_on = 0;
    // short sync leaves lanes partly ramped
    word_a = 16'h1FFF; start_a = 16'h8000; word_b = 16'h0010; start_b = 16'h0000;
    sync = 1; cyc(5); sync = 0; cyc(20);
    // zero word: lanes stay at start
    word_a = 0; word_b = 0; start_a = 16'hABCD; start_b = 16'h1234;
    sync = 1; cyc(17); sync = 0;
    ca_word = 0; ca_start = 16'hABCD; cb_word = 0; cb_start = 16'h1234;
    n_after = 0; closed_on = 1;
    cyc(10);
    closed_on = 0;
    // R1: reset mid-run
    rst = 1; cyc(1);
    chk(phase_a[255:240], 0, "R1 mid reset lane A15");
    chk(samples[31:16], 0, "R1 mid reset sample1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule